// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block is a purely combinational priority encoder. Every request, enable and result line is active low. Each eight-line stage reports the index of the highest-numbered request that is asserted, as an inverted binary code.

Each stage also drives two flags:
- A group-select flag, which means that some request was seen.
- A pass-down enable, which hands control to the next stage of lower priority when the stage sees no request.

The top level chains a parameterized number of stages. By default there are two stages, which gives a 16-line encoder. The pass-down enable of each stage drives the enable of the stage below it. The per-stage codes are combined into one wider code.

Use it wherever a wide set of active-low interrupt or request lines must be reduced to a single winner index in the same cycle. The group-select output separates "request 0 won" from "nothing asserted". The final pass-down enable can feed a further encoder below this one.

Top module: `prio_enc_cascade`

## Requirements
- R1: While `en_ni` is high, every code bit, `gs_no` and `eo_no` are high, whatever the request lines carry.
- R2: While enabled, the code is the bitwise inverse of the index of the highest-numbered request line that is low. For example, on one 8-line stage with only line 5 low, the code reads 3'b010.
- R3: `gs_no` is low exactly when `en_ni` is low and at least one request line is low.
- R4: `eo_no` is low exactly when `en_ni` is low and every request line is high.
- R5: While enabled with no request low, every code bit is high. This is the same code as request 0.
- R6: In the cascade, any low request in the upper stage (lines 8..15 by default) masks all lower-stage requests. The lower stage is enabled only through the upper stage's `eo_no`.
- R7: In the cascade, code bit 3 is the upper stage's group select. Bits 2..0 are the AND of both stages' active-low codes. Together they form the inverted 4-bit winner index.
- R8: In the cascade, `gs_no` is low when either stage's group select is low.
- R9: `gs_no` and `eo_no` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_ni | input | 1 | Active-low enable of the highest-priority stage |
| req_ni | input | N_STAGES*8 | Active-low request lines; a higher index has higher priority |
| code_no | output | 3+log2(N_STAGES) | Active-low binary index of the winning request |
| gs_no | output | 1 | Active-low group select: enabled and a request was seen |
| eo_no | output | 1 | Active-low pass-down enable: enabled and no request seen |

## Verification
The bench builds the top with its default of two stages, so that the 16-line cascade is covered: all 2^17 combinations of enable and request lines are applied. Beside it, a single 8-line stage is driven with the same enable and low byte, which covers all 512 stage combinations many times over. With two stages the bench can reach the cascade-specific behaviour: upper-stage requests masking lower ones, code bit 3 coming from the upper group select, and the pass-down enable travelling through both stages.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
  localparam int unsigned LANES_PER_STAGE = 8;
  localparam int unsigned STAGE_IDX_W     = $clog2(LANES_PER_STAGE);
endpackage

// File: rtl/prio_enc_stage.sv
module prio_enc_stage #(
  parameter int unsigned LANES = prio_enc_pkg::LANES_PER_STAGE,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic             en_ni,
  input  logic [LANES-1:0] req_ni,
  output logic [IDX_W-1:0] code_no,
  output logic             gs_no,
  output logic             eo_no
);
  logic             hit;
  logic [IDX_W-1:0] idx;

  // ascending scan: the last low line seen is the highest-numbered one
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!req_ni[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    code_no = '1;
    gs_no   = 1'b1;
    eo_no   = 1'b1;
    if (!en_ni) begin
      code_no = ~idx;
      gs_no   = ~hit;
      eo_no   = hit;
    end
  end
endmodule

// File: rtl/prio_enc_merge.sv
module prio_enc_merge #(
  parameter int unsigned N_STAGES = 2,
  parameter int unsigned IDX_W    = 3,
  localparam int unsigned SEL_W   = $clog2(N_STAGES)
) (
  input  logic [N_STAGES*IDX_W-1:0] stage_code_ni,
  input  logic [N_STAGES-1:0]       stage_gs_ni,
  output logic [SEL_W+IDX_W-1:0]    code_no,
  output logic                      gs_no
);
  logic [IDX_W-1:0] low_code;
  logic [SEL_W-1:0] sel_n;

  // at most one stage is active, so ANDing the active-low codes picks it
  always_comb begin
    low_code = '1;
    for (int s = 0; s < N_STAGES; s++) low_code &= stage_code_ni[s*IDX_W +: IDX_W];
  end

  // upper bits: inverted index of the stage whose group select is low
  always_comb begin
    sel_n = '1;
    for (int s = 0; s < N_STAGES; s++) begin
      for (int b = 0; b < SEL_W; b++) begin
        if (((s >> b) & 1) == 1 && !stage_gs_ni[s]) sel_n[b] = 1'b0;
      end
    end
  end

  assign code_no = {sel_n, low_code};
  assign gs_no   = &stage_gs_ni;
endmodule

// File: rtl/prio_enc_cascade.sv
module prio_enc_cascade #(
  parameter int unsigned N_STAGES = 2,
  localparam int unsigned LANES   = prio_enc_pkg::LANES_PER_STAGE,
  localparam int unsigned IDX_W   = prio_enc_pkg::STAGE_IDX_W,
  localparam int unsigned N_REQ   = N_STAGES * LANES,
  localparam int unsigned CODE_W  = $clog2(N_REQ)
) (
  input  logic              en_ni,
  input  logic [N_REQ-1:0]  req_ni,
  output logic [CODE_W-1:0] code_no,
  output logic              gs_no,
  output logic              eo_no
);
  logic [N_STAGES:0]         chain_en_n;  // [N_STAGES] is the top enable
  logic [N_STAGES*IDX_W-1:0] stage_code_n;
  logic [N_STAGES-1:0]       stage_gs_n;

  assign chain_en_n[N_STAGES] = en_ni;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    prio_enc_stage #(.LANES(LANES)) u_stage (
      .en_ni   (chain_en_n[s+1]),
      .req_ni  (req_ni[s*LANES +: LANES]),
      .code_no (stage_code_n[s*IDX_W +: IDX_W]),
      .gs_no   (stage_gs_n[s]),
      .eo_no   (chain_en_n[s])
    );
  end

  prio_enc_merge #(.N_STAGES(N_STAGES), .IDX_W(IDX_W)) u_merge (
    .stage_code_ni (stage_code_n),
    .stage_gs_ni   (stage_gs_n),
    .code_no       (code_no),
    .gs_no         (gs_no)
  );

  assign eo_no = chain_en_n[0];
endmodule

// File: rtl/prio_enc_cascade_chk.sv
module prio_enc_cascade_chk #(
  parameter int unsigned N_REQ  = 16,
  parameter int unsigned CODE_W = 4
) (
  input logic              en_ni,
  input logic [N_REQ-1:0]  req_ni,
  input logic [CODE_W-1:0] code_no,
  input logic              gs_no,
  input logic              eo_no
);
  logic              any_req;
  logic [CODE_W-1:0] win;
  logic              win_ok;

  always_comb begin
    any_req = ~&req_ni;
    win     = ~code_no;
    win_ok  = !req_ni[win];
    for (int i = 0; i < N_REQ; i++) if (i > int'(win) && !req_ni[i]) win_ok = 1'b0;
  end

  always_comb begin
    // R1
    dis_quiet_chk: assert (!en_ni || (&code_no && gs_no && eo_no))
      else $error("R1 disabled outputs not high");
    // R3
    gs_match_chk: assert (gs_no == !(!en_ni && any_req))
      else $error("R3 group select mismatch");
    // R4
    eo_match_chk: assert (eo_no == !(!en_ni && !any_req))
      else $error("R4 enable out mismatch");
    // R2
    winner_chk: assert (en_ni || gs_no || win_ok)
      else $error("R2 code is not the highest asserted request");
    // R5
    idle_code_chk: assert (en_ni || !gs_no || &code_no)
      else $error("R5 idle code not all high");
    // R9
    flag_excl_chk: assert (gs_no || eo_no)
      else $error("R9 gs and eo both low");
  end
endmodule

bind prio_enc_cascade prio_enc_cascade_chk #(.N_REQ(N_REQ), .CODE_W(CODE_W)) u_chk (
  .en_ni   (en_ni),
  .req_ni  (req_ni),
  .code_no (code_no),
  .gs_no   (gs_no),
  .eo_no   (eo_no)
);

// File: tb/prio_enc_cascade_tb.sv
module prio_enc_cascade_tb;
  logic        clk = 1'b0;
  logic        en_n = 1'b1;
  logic [15:0] req_n = '1;
  logic [3:0]  code_n;
  logic        gs_n, eo_n;
  logic [2:0]  s_code_n;
  logic        s_gs_n, s_eo_n;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prio_enc_cascade #(.N_STAGES(2)) u_dut (
    .en_ni(en_n), .req_ni(req_n), .code_no(code_n), .gs_no(gs_n), .eo_no(eo_n)
  );

  prio_enc_stage #(.LANES(8)) u_stage (
    .en_ni(en_n), .req_ni(req_n[7:0]), .code_no(s_code_n), .gs_no(s_gs_n), .eo_no(s_eo_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h en_n=%b req_n=%h", tag, act, exp, en_n, req_n);
    end
  endtask

  // returns {eo_n, gs_n, code_n[3:0]} for an n-line encoder (n = 8 or 16)
  function automatic logic [5:0] model(input logic e_n, input logic [15:0] r, input int n);
    int  top = -1;
    logic [3:0] c;
    for (int i = 0; i < n; i++) if (!r[i]) top = i;
    if (e_n) return {2'b11, (n == 16) ? 4'hF : 4'h7};
    if (top < 0) return {2'b01, (n == 16) ? 4'hF : 4'h7};
    c = ~4'(top);
    if (n == 8) c[3] = 1'b0;
    return {2'b10, c};
  endfunction

  initial begin
    @(negedge clk);
    // reset-state: disabled, idle
    chk("R1 initial code", int'(code_n), 15);
    chk("R1 initial gs", int'(gs_n), 1);
    chk("R1 initial eo", int'(eo_n), 1);
    // single-stage example: line 5 alone -> 3'b010
    @(posedge clk); en_n = 1'b0; req_n = 16'hFFDF;
    @(negedge clk);
    chk("R2 stage line5 code", int'(s_code_n), 2);
    chk("R7 cascade line5 code", int'(code_n), 4'hA);
    for (int v = 0; v < (1 << 17); v++) begin
      logic [5:0] ec, es;
      @(posedge clk);
      en_n  = v[16];
      req_n = v[15:0];
      @(negedge clk);
      ec = model(en_n, req_n, 16);
      es = model(en_n, req_n, 8);
      // stage: all 512 combos of enable and low byte occur
      chk(en_n ? "R1 stage code" : (s_gs_n ? "R5 stage code" : "R2 stage code"),
          int'(s_code_n), int'(es[2:0]));
      chk(en_n ? "R1 stage gs" : "R3 stage gs", int'(s_gs_n), int'(es[4]));
      chk(en_n ? "R1 stage eo" : "R4 stage eo", int'(s_eo_n), int'(es[5]));
      // cascade
      chk(en_n ? "R1 code" : (ec[4] ? "R5 code" : "R7 code"), int'(code_n), int'(ec[3:0]));
      chk(en_n ? "R1 gs" : "R8 gs", int'(gs_n), int'(ec[4]));
      chk(en_n ? "R1 eo" : "R4 eo", int'(eo_n), int'(ec[5]));
      chk("R9 flags exclusive", int'(gs_n | eo_n), 1);
      if (!en_n && req_n[15:8] != 8'hFF)
        chk("R6 upper masks lower", int'(code_n[3]), 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule